// File: doc/BRIEF.md
# Add-Only Memory Program Controller

This block holds a small one-time-programmable store. It has a 128-byte data array, split into four pages of 32 bytes, and an 8-byte status area. Every bit starts erased at 1. Programming can only clear bits, so a commit stores the AND of the old byte and the new pattern. Existing data stays put while new data is added alongside it.

A host does not write the array directly. It first stages a byte in a one-byte scratchpad. The block answers with the CRC-8 of that staged byte, so the host can confirm the byte arrived intact before it spends a programming pulse. The commit then succeeds only while the programming-voltage flag is high and the target page is not locked. Status byte 0 carries one lock bit per data page, and a lock bit that has been programmed to 0 freezes that page against writes. Reads of a locked page still work. A refused commit raises a one-cycle error pulse. A successful commit returns the newly stored byte on a read-back output, so the host can verify it.

Top module: `aom_prog_ctrl`

## Requirements
- R1: After reset, every array and status byte reads 0xFF. `rdata`, `readback` and `crc_out` are 0x00, and `prog_err`, `rd_valid` and `rb_valid` are 0.
- R2: A `load` cycle stores `wdata` in the scratchpad. From the next cycle, `crc_out` holds the CRC-8 of that byte: reflected polynomial 0x8C (x^8+x^5+x^4+1), initial value 0, bits taken least significant first. It holds that value until the next load.
- R3: An `rd_en` cycle sets `rd_valid` one cycle later, with `rdata` holding the addressed byte. With `stat_sel`=0 that byte is array byte `addr`; with `stat_sel`=1 it is status byte `addr[2:0]`.
- R4: An accepted `prog_en` cycle replaces the addressed byte with (old byte AND scratchpad). A bit at 0 never returns to 1.
- R5: One cycle after an accepted commit, `rb_valid` is 1 and `readback` equals the newly stored byte.
- R6: A `prog_en` cycle with `vpp_ok`=0 leaves memory unchanged. One cycle later `prog_err` is 1 and `rb_valid` is 0, and `prog_err` falls again the cycle after that.
- R7: The page of an array address is `addr[6:5]`. When bit p of status byte 0 is 0, every program request to page p is refused, with the same effect as R6. Reads of that page still return its data, and the other pages stay writable.
- R8: Status bytes follow the same AND rule and the same voltage gate as the array, but page locks do not apply to them.
- R9: When `prog_en` and `rd_en` are both high in one cycle, the program wins and no read is reported. A `load` in the same cycle as a commit takes effect only after the commit, which uses the previous scratchpad.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; restores the erased state |
| stat_sel | input | 1 | 1 selects the status area, 0 selects the data array |
| addr | input | 7 | Byte address (only the low 3 bits are used in the status area) |
| wdata | input | 8 | Byte to stage in the scratchpad |
| load | input | 1 | Stage `wdata` into the scratchpad |
| rd_en | input | 1 | Read request |
| prog_en | input | 1 | Program (commit) request |
| vpp_ok | input | 1 | Programming voltage present |
| rdata | output | 8 | Read data |
| rd_valid | output | 1 | `rdata` valid this cycle |
| crc_out | output | 8 | CRC-8 of the staged byte |
| readback | output | 8 | Byte stored by the last accepted commit |
| rb_valid | output | 1 | `readback` valid this cycle |
| prog_err | output | 1 | One-cycle pulse for a refused commit |

## Verification
The hardest state to reach is a locked page. Getting there takes a full programming pass on status byte 0: stage a pattern with one cleared bit, then commit it with the voltage present. Only after that can a data write be shown to be refused while a read of the same page still succeeds. The stimulus table does exactly that. It follows with a commit to a different page to show that the lock is local to one page. Repeated commits to one byte, with a re-staged all-ones pattern in between, show that cleared bits stay cleared. A separate directed step drives a load, a read and a commit in the same cycle to expose their ordering.

// File: rtl/aom_pkg.sv
package aom_pkg;

    localparam int PAGE_COUNT   = 4;
    localparam int BYTES_PER_PG = 32;
    localparam int STATUS_BYTES = 8;
    localparam int DATA_W       = 8;
    localparam logic [7:0] CRC_POLY_REFL = 8'h8C;

    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_READ = 2'd1,
        OP_PROG = 2'd2
    } aom_op_e;

    typedef struct packed {
        logic allowed;
        logic refused;
    } aom_verdict_t;

    // Serial CRC-8 over one byte, least significant bit first.
    function automatic logic [7:0] crc8_step_byte(input logic [7:0] seed,
                                                  input logic [7:0] d);
        logic [7:0] c;
        logic       mix;
        c = seed;
        for (int i = 0; i < 8; i++) begin
            mix = c[0] ^ d[i];
            c   = c >> 1;
            if (mix) c = c ^ CRC_POLY_REFL;
        end
        return c;
    endfunction

endpackage

// File: rtl/aom_scratch.sv
module aom_scratch
    import aom_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic [W-1:0] stage_q,
    output logic [7:0]   crc_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '1;
            crc_q   <= '0;
        end else if (load) begin
            stage_q <= din;
            crc_q   <= crc8_step_byte(8'h00, din[7:0]);
        end
    end

    // R2: staged byte follows the load strobe
    assert_stage_follows_load_R2: assert property (@(posedge clk) disable iff (rst)
        load |=> (stage_q == $past(din)));

    // R2: CRC only moves on a load
    assert_crc_held_R2: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(crc_q));

endmodule

// File: rtl/aom_store.sv
module aom_store
    import aom_pkg::*;
#(
    parameter int PAGES   = PAGE_COUNT,
    parameter int PG_SIZE = BYTES_PER_PG,
    parameter int STAT_N  = STATUS_BYTES,
    parameter int W       = DATA_W
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 wr_en,
    input  logic                                 sel_stat,
    input  logic [$clog2(PAGES*PG_SIZE)-1:0]     addr,
    input  logic [W-1:0]                         mask,
    output logic [W-1:0]                         rd_byte,
    output logic [W-1:0]                         wb_q,
    output logic [PAGES-1:0]                     page_open
);

    localparam int ARR_N  = PAGES * PG_SIZE;
    localparam int AW     = $clog2(ARR_N);
    localparam int SAW    = $clog2(STAT_N);
    localparam int PW     = $clog2(PAGES);

    logic [W-1:0] arr_mem  [ARR_N];
    logic [W-1:0] stat_mem [STAT_N];
    logic [SAW-1:0] s_idx;
    logic [W-1:0]   cur_byte;

    assign s_idx    = addr[SAW-1:0];
    assign cur_byte = sel_stat ? stat_mem[s_idx] : arr_mem[addr];
    assign rd_byte  = cur_byte;

    // One lock bit per page in status byte 0; 1 means still open.
    for (genvar p = 0; p < PAGES; p++) begin : g_lock
        assign page_open[p] = stat_mem[0][p];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ARR_N; i++)  arr_mem[i]  <= '1;
            for (int j = 0; j < STAT_N; j++) stat_mem[j] <= '1;
            wb_q <= '0;
        end else if (wr_en) begin
            if (sel_stat) stat_mem[s_idx] <= stat_mem[s_idx] & mask;
            else          arr_mem[addr]   <= arr_mem[addr] & mask;
            wb_q <= cur_byte & mask;
        end
    end

    logic [PW-1:0] wr_page;
    assign wr_page = addr[AW-1 -: PW];

    // R7: an array write never lands in a locked page
    assert_no_write_locked_page_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !sel_stat) |-> page_open[wr_page]);

    // R4: the addressed byte gains no 1 bits across a write
    assert_add_only_R4: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> ((rd_byte & ~$past(cur_byte)) == '0) || !$stable(addr) || !$stable(sel_stat));

endmodule

// File: rtl/aom_ctrl.sv
module aom_ctrl
    import aom_pkg::*;
#(
    parameter int PAGES  = PAGE_COUNT,
    parameter int ADDR_W = $clog2(PAGE_COUNT * BYTES_PER_PG)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              prog_en,
    input  logic              rd_en,
    input  logic              vpp_ok,
    input  logic              stat_sel,
    input  logic [ADDR_W-1:0] addr,
    input  logic [PAGES-1:0]  page_open,
    output logic              wr_en,
    output logic              rd_go,
    output logic              prog_err,
    output logic              rd_valid,
    output logic              rb_valid
);

    localparam int PW = $clog2(PAGES);

    aom_op_e       op;
    aom_verdict_t  verdict;
    logic [PW-1:0] page;

    assign page = addr[ADDR_W-1 -: PW];

    always_comb begin
        if (prog_en)    op = OP_PROG;
        else if (rd_en) op = OP_READ;
        else            op = OP_IDLE;

        verdict.allowed = vpp_ok && (stat_sel || page_open[page]);
        verdict.refused = (op == OP_PROG) && !verdict.allowed;
    end

    assign wr_en = (op == OP_PROG) && verdict.allowed;
    assign rd_go = (op == OP_READ);

    always_ff @(posedge clk) begin
        if (rst) begin
            prog_err <= 1'b0;
            rd_valid <= 1'b0;
            rb_valid <= 1'b0;
        end else begin
            prog_err <= verdict.refused;
            rd_valid <= rd_go;
            rb_valid <= wr_en;
        end
    end

    // R6: a refusal and a read-back never appear together
    assert_err_excludes_rb_R6: assert property (@(posedge clk) disable iff (rst)
        !(prog_err && rb_valid));

    // R6: an error pulse only follows a program request
    assert_err_needs_prog_R6: assert property (@(posedge clk) disable iff (rst)
        prog_err |-> $past(prog_en));

    // R9: a read is reported only when no program shared its cycle
    assert_read_yields_R9: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> ($past(rd_en) && !$past(prog_en)));

    // R6: missing voltage always refuses a program request
    assert_no_vpp_refuses_R6: assert property (@(posedge clk) disable iff (rst)
        (prog_en && !vpp_ok) |=> prog_err);

endmodule

// File: rtl/aom_prog_ctrl.sv
module aom_prog_ctrl
    import aom_pkg::*;
#(
    parameter int PAGES   = PAGE_COUNT,
    parameter int PG_SIZE = BYTES_PER_PG,
    parameter int STAT_N  = STATUS_BYTES,
    parameter int W       = DATA_W,
    localparam int AW     = $clog2(PAGES * PG_SIZE)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          stat_sel,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    input  logic          load,
    input  logic          rd_en,
    input  logic          prog_en,
    input  logic          vpp_ok,
    output logic [W-1:0]  rdata,
    output logic          rd_valid,
    output logic [7:0]    crc_out,
    output logic [W-1:0]  readback,
    output logic          rb_valid,
    output logic          prog_err
);

    logic [W-1:0]     stage_q;
    logic [W-1:0]     rd_byte;
    logic [PAGES-1:0] page_open;
    logic             wr_en;
    logic             rd_go;

    aom_scratch #(.W(W)) u_scratch (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .din     (wdata),
        .stage_q (stage_q),
        .crc_q   (crc_out)
    );

    aom_ctrl #(.PAGES(PAGES), .ADDR_W(AW)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .prog_en   (prog_en),
        .rd_en     (rd_en),
        .vpp_ok    (vpp_ok),
        .stat_sel  (stat_sel),
        .addr      (addr),
        .page_open (page_open),
        .wr_en     (wr_en),
        .rd_go     (rd_go),
        .prog_err  (prog_err),
        .rd_valid  (rd_valid),
        .rb_valid  (rb_valid)
    );

    aom_store #(.PAGES(PAGES), .PG_SIZE(PG_SIZE), .STAT_N(STAT_N), .W(W)) u_store (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .sel_stat  (stat_sel),
        .addr      (addr),
        .mask      (stage_q),
        .rd_byte   (rd_byte),
        .wb_q      (readback),
        .page_open (page_open)
    );

    always_ff @(posedge clk) begin
        if (rst)        rdata <= '0;
        else if (rd_go) rdata <= rd_byte;
    end

    // R5: a read-back byte carries no bit the scratchpad had cleared
    assert_readback_masked_R5: assert property (@(posedge clk) disable iff (rst)
        rb_valid |-> ((readback & ~$past(stage_q)) == '0));

endmodule

// File: tb/aom_prog_ctrl_tb.sv
module aom_prog_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam logic [1:0] T_LOAD = 2'd0;
    localparam logic [1:0] T_PROG = 2'd1;
    localparam logic [1:0] T_READ = 2'd2;
    localparam int NV = 22;

    // {op[27:26], sel[25], addr[24:18], data[17:10], vpp[9], expect[8:1], err[0]}
    localparam logic [27:0] VEC [NV] = '{
        {T_READ, 1'b0, 7'h00, 8'h00, 1'b0, 8'hFF, 1'b0},  // R1 erased array
        {T_LOAD, 1'b0, 7'h00, 8'hA5, 1'b0, 8'h00, 1'b0},  // R2
        {T_PROG, 1'b0, 7'h05, 8'h00, 1'b1, 8'hA5, 1'b0},  // R4 R5
        {T_LOAD, 1'b0, 7'h00, 8'h3C, 1'b0, 8'h00, 1'b0},
        {T_PROG, 1'b0, 7'h05, 8'h00, 1'b1, 8'h24, 1'b0},  // R4 AND
        {T_LOAD, 1'b0, 7'h00, 8'hFF, 1'b0, 8'h00, 1'b0},
        {T_PROG, 1'b0, 7'h05, 8'h00, 1'b1, 8'h24, 1'b0},  // R4 no 0->1
        {T_READ, 1'b0, 7'h05, 8'h00, 1'b0, 8'h24, 1'b0},  // R3
        {T_LOAD, 1'b0, 7'h00, 8'h00, 1'b0, 8'h00, 1'b0},
        {T_PROG, 1'b0, 7'h10, 8'h00, 1'b0, 8'h00, 1'b1},  // R6 no voltage
        {T_READ, 1'b0, 7'h10, 8'h00, 1'b0, 8'hFF, 1'b0},  // R6 unchanged
        {T_LOAD, 1'b0, 7'h00, 8'hFD, 1'b0, 8'h00, 1'b0},
        {T_PROG, 1'b1, 7'h00, 8'h00, 1'b1, 8'hFD, 1'b0},  // R8 lock page 1
        {T_LOAD, 1'b0, 7'h00, 8'h00, 1'b0, 8'h00, 1'b0},
        {T_PROG, 1'b0, 7'h20, 8'h00, 1'b1, 8'h00, 1'b1},  // R7 locked
        {T_PROG, 1'b0, 7'h3F, 8'h00, 1'b1, 8'h00, 1'b1},  // R7 locked, last byte
        {T_READ, 1'b0, 7'h20, 8'h00, 1'b0, 8'hFF, 1'b0},  // R7 read still ok
        {T_PROG, 1'b0, 7'h7F, 8'h00, 1'b1, 8'h00, 1'b0},  // R7 page 3 open
        {T_READ, 1'b1, 7'h00, 8'h00, 1'b0, 8'hFD, 1'b0},  // R3 status read
        {T_LOAD, 1'b0, 7'h00, 8'h0F, 1'b0, 8'h00, 1'b0},
        {T_PROG, 1'b1, 7'h03, 8'h00, 1'b1, 8'h0F, 1'b0},  // R8 no lock on status
        {T_LOAD, 1'b0, 7'h00, 8'h5A, 1'b0, 8'h00, 1'b0}   // R2
    };

    logic       clk = 1'b0;
    logic       rst;
    logic       stat_sel, load, rd_en, prog_en, vpp_ok;
    logic [6:0] addr;
    logic [7:0] wdata;
    logic [7:0] rdata, crc_out, readback;
    logic       rd_valid, rb_valid, prog_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    aom_prog_ctrl u_dut (
        .clk(clk), .rst(rst), .stat_sel(stat_sel), .addr(addr), .wdata(wdata),
        .load(load), .rd_en(rd_en), .prog_en(prog_en), .vpp_ok(vpp_ok),
        .rdata(rdata), .rd_valid(rd_valid), .crc_out(crc_out),
        .readback(readback), .rb_valid(rb_valid), .prog_err(prog_err)
    );

    function automatic logic [7:0] ref_crc(input logic [7:0] d);
        logic [7:0] c = 8'h00;
        for (int i = 0; i < 8; i++) begin
            if (c[0] ^ d[i]) c = (c >> 1) ^ 8'h8C;
            else             c = c >> 1;
        end
        return c;
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        load = 0; rd_en = 0; prog_en = 0; vpp_ok = 0;
    endtask

    task automatic run_vec(input logic [27:0] v);
        @(negedge clk);
        stat_sel = v[25]; addr = v[24:18]; wdata = v[17:10]; vpp_ok = v[9];
        load    = (v[27:26] == T_LOAD);
        prog_en = (v[27:26] == T_PROG);
        rd_en   = (v[27:26] == T_READ);
        @(negedge clk);
        idle_inputs();
        case (v[27:26])
            T_LOAD: check("R2 crc", {8'h0, crc_out}, {8'h0, ref_crc(v[17:10])});
            T_READ: check("R3 read", {7'h0, rd_valid, rdata}, {7'h0, 1'b1, v[8:1]});
            default: begin
                if (v[0]) check("R6/R7 refused", {6'h0, prog_err, rb_valid, 8'h0}, {6'h0, 2'b10, 8'h0});
                else      check("R4/R5 commit", {6'h0, prog_err, rb_valid, readback}, {6'h0, 2'b01, v[8:1]});
            end
        endcase
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1; stat_sel = 0; addr = '0; wdata = '0;
        idle_inputs();
        repeat (3) @(negedge clk);
        // R1 reset outputs
        check("R1 outputs", {rdata, crc_out}, 16'h0000);
        check("R1 flags", {8'h0, readback}, 16'h0000);
        check("R1 strobes", {13'h0, prog_err, rd_valid, rb_valid}, 16'h0000);
        rst = 0;

        for (int k = 0; k < NV; k++) run_vec(VEC[k]);

        // R6 error is a single-cycle pulse
        run_vec({T_PROG, 1'b0, 7'h11, 8'h00, 1'b0, 8'h00, 1'b1});
        @(negedge clk);
        check("R6 pulse width", {15'h0, prog_err}, 16'h0000);

        // R9: prog + read + load in one cycle
        run_vec({T_LOAD, 1'b0, 7'h00, 8'hF0, 1'b0, 8'h00, 1'b0});
        @(negedge clk);
        stat_sel = 0; addr = 7'h40; wdata = 8'h11; vpp_ok = 1;
        prog_en = 1; rd_en = 1; load = 1;
        @(negedge clk);
        idle_inputs();
        check("R9 prog wins", {6'h0, rd_valid, rb_valid, readback}, {6'h0, 2'b01, 8'hF0});
        run_vec({T_PROG, 1'b0, 7'h40, 8'h00, 1'b1, 8'h10, 1'b0});  // R9 new scratch used next

        // R1 reset restores the erased state
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0;
        run_vec({T_READ, 1'b0, 7'h05, 8'h00, 1'b0, 8'hFF, 1'b0});  // R1
        run_vec({T_READ, 1'b1, 7'h00, 8'h00, 1'b0, 8'hFF, 1'b0});  // R1 status
        run_vec({T_LOAD, 1'b0, 7'h00, 8'h00, 1'b0, 8'h00, 1'b0});
        run_vec({T_PROG, 1'b0, 7'h20, 8'h00, 1'b1, 8'h00, 1'b0});  // R7 lock cleared by reset

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule